// File: doc/BRIEF.md
# Two-Symbol Video Channel Encoder

This block turns two 8-bit pixel component values per clock into two 10-bit transition-minimized, DC-balanced symbols and packs them into one 20-bit word for a 20:1 serializer downstream. It is the data-period part of a digital display link channel. Control tokens, guard bands, auxiliary data islands and the serializer sit outside the block.

The work is split across three register stages, and two lookup tables hold most of the logic. The first table has 256 entries and is addressed by the incoming byte. Each entry holds the 9-bit transition-minimized word and a coarse balance class. The middle stage chains the running disparity through both symbols of the cycle and decides, for each symbol, whether its data bits are inverted. It forms a 10-bit index from that decision. The last stage maps each index through a 1024-entry table to the final symbol. Package functions compute the contents of both tables at elaboration.

Top module: `tmds_dual_enc`

## Requirements
- R1: Each valid output word holds two symbols. The symbol for input bits [7:0] is in word bits [9:0], and the symbol for input bits [15:8] is in word bits [19:10].
- R2: The 9-bit intermediate word starts from bit 0 equal to data bit 0. If the data has more than four ones, or exactly four ones with bit 0 clear, each further bit is the XNOR of the previous intermediate bit and the data bit, and bit 8 is 0. Otherwise XOR is used and bit 8 is 1.
- R3: Let n be the ones count of intermediate bits [7:0].
  - If the running disparity is zero or n equals 4, symbol bit 9 is the inverse of intermediate bit 8.
  - If the disparity is positive and n > 4, or negative and n < 4, bit 9 is 1.
  - Otherwise bit 9 is 0.
  - Bit 8 always equals intermediate bit 8. Bits [7:0] are the intermediate bits inverted when bit 9 is 1.
  - The disparity then changes by the symbol's ones minus zeros over all 10 bits.
- R4: The second symbol of a cycle is encoded with the running disparity as already changed by the first symbol of that cycle.
- R5: The running disparity carries from cycle to cycle and does not change in cycles where data-enable is low.
- R6: Output valid and the output word appear on the third rising edge counting the edge that samples the inputs, and valid follows data-enable with exactly that delay.
- R7: While output valid is low the output word is all zeros.
- R8: Reset clears valid and the output word, and sets the running disparity to zero. After reset, a first pair of 0x00 bytes gives the word 0xFFD00.
- R9: The running disparity stays even and within -8 to +8 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_de | input | 1 | Data-enable qualifying the two input bytes |
| vid_data | input | 16 | Two input bytes, first in [7:0], second in [15:8] |
| ser_word | output | 20 | Two packed 10-bit symbols for the serializer |
| ser_valid | output | 1 | Qualifies ser_word |

## Verification
The assertions check four properties on every cycle: the three-cycle alignment of valid with data-enable, the zero word while valid is low, the disparity hold in enable-low cycles, and the evenness and ±8 bound of the internal disparity counter. The correctness of each symbol cannot be seen by a property. The chaining of disparity from the first to the second symbol is also invisible to a property. Only the bench's scenarios show these two things. They compare every output word with an independent bit-serial encoder run on the same byte stream. The stream covers edge bytes, long unbalanced runs, gaps in data-enable and a long pseudo-random sequence.

// File: rtl/tmds_dual_pkg.sv
package tmds_dual_pkg;

  localparam int BYTE_W = 8;
  localparam int QM_W   = 9;
  localparam int SYM_W  = 10;
  localparam int DISP_W = 6;

  typedef logic signed [DISP_W-1:0] disp_t;

  // coarse balance of the 8 low intermediate bits
  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_POS  = 2'b01,
    CLS_NEG  = 2'b10
  } bal_cls_e;

  // first table entry: 12 bits
  typedef struct packed {
    logic       spare;
    bal_cls_e   cls;
    logic [8:0] qm;
  } lut_ent_t;

  typedef struct packed {
    logic  inv;
    disp_t nxt;
  } step_t;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

  function automatic logic [8:0] min_trans(input logic [7:0] d);
    logic [8:0] q;
    logic       use_xnor;
    use_xnor = (ones8(d) > 4'd4) || ((ones8(d) == 4'd4) && !d[0]);
    q[0] = d[0];
    for (int i = 1; i < 8; i++)
      q[i] = use_xnor ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q[8] = ~use_xnor;
    return q;
  endfunction

  function automatic lut_ent_t byte_entry(input logic [7:0] d);
    lut_ent_t   e;
    logic [3:0] n;
    e.qm  = min_trans(d);
    n     = ones8(e.qm[7:0]);
    e.cls = (n == 4'd4) ? CLS_ZERO : ((n > 4'd4) ? CLS_POS : CLS_NEG);
    e.spare = 1'b0;
    return e;
  endfunction

  // index = {invert, qm[8:0]}
  function automatic logic [9:0] final_code(input logic [9:0] idx);
    return {idx[9], idx[8], idx[9] ? ~idx[7:0] : idx[7:0]};
  endfunction

  function automatic step_t disp_step(input disp_t cnt, input lut_ent_t e);
    step_t r;
    disp_t diff;
    diff = $signed({1'b0, ones8(e.qm[7:0]), 1'b0}) - 6'sd8;
    if (cnt == 0 || e.cls == CLS_ZERO) begin
      r.inv = ~e.qm[8];
      r.nxt = r.inv ? (cnt - diff) : (cnt + diff);
    end else if ((cnt > 0 && e.cls == CLS_POS) || (cnt < 0 && e.cls == CLS_NEG)) begin
      r.inv = 1'b1;
      r.nxt = cnt + (e.qm[8] ? 6'sd2 : 6'sd0) - diff;
    end else begin
      r.inv = 1'b0;
      r.nxt = cnt - (e.qm[8] ? 6'sd0 : 6'sd2) + diff;
    end
    return r;
  endfunction

endpackage

// File: rtl/tmds_byte_lut.sv
module tmds_byte_lut
  import tmds_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] addr,
  output lut_ent_t          ent_q
);

  localparam int DEPTH = 1 << BYTE_W;

  lut_ent_t rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = byte_entry(BYTE_W'(a));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= '0;
    else        ent_q <= rom[addr];
  end

endmodule

// File: rtl/tmds_disp_chain.sv
module tmds_disp_chain
  import tmds_dual_pkg::*;
#(
  parameter int SYMS = 2
) (
  input  disp_t                rd_in,
  input  lut_ent_t [SYMS-1:0]  ent,
  output logic     [SYMS-1:0]  inv,
  output disp_t                rd_out
);

  always_comb begin
    disp_t acc;
    step_t st;
    acc = rd_in;
    inv = '0;
    for (int k = 0; k < SYMS; k++) begin
      st     = disp_step(acc, ent[k]);
      inv[k] = st.inv;
      acc    = st.nxt;
    end
    rd_out = acc;
  end

endmodule

// File: rtl/tmds_code_lut.sv
module tmds_code_lut
  import tmds_dual_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [SYM_W-1:0] idx,
  output logic [SYM_W-1:0] code_q
);

  localparam int DEPTH = 1 << SYM_W;

  logic [SYM_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom[a] = final_code(SYM_W'(a));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code_q <= '0;
    else if (vld) code_q <= rom[idx];
    else          code_q <= '0;
  end

endmodule

// File: rtl/tmds_dual_enc.sv
module tmds_dual_enc
  import tmds_dual_pkg::*;
#(
  parameter int SYMS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vid_de,
  input  logic [BYTE_W*SYMS-1:0]  vid_data,
  output logic [SYM_W*SYMS-1:0]   ser_word,
  output logic                    ser_valid
);

  // stage 1: per-byte table lookup
  lut_ent_t [SYMS-1:0] s1_ent;
  logic                s1_de;

  for (genvar k = 0; k < SYMS; k++) begin : g_s1
    tmds_byte_lut u_blut (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (vid_data[k*BYTE_W +: BYTE_W]),
      .ent_q (s1_ent[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_de <= 1'b0;
    else        s1_de <= vid_de;
  end

  // stage 2: disparity chain and index formation
  disp_t                        rd_q;
  disp_t                        rd_next;
  logic  [SYMS-1:0]             s1_inv;
  logic                         rd_upd;
  logic  [SYMS-1:0][SYM_W-1:0]  s2_idx;
  logic                         s2_de;

  tmds_disp_chain #(.SYMS(SYMS)) u_chain (
    .rd_in  (rd_q),
    .ent    (s1_ent),
    .inv    (s1_inv),
    .rd_out (rd_next)
  );

  assign rd_upd = s1_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      s2_de  <= 1'b0;
      s2_idx <= '0;
    end else begin
      if (rd_upd) rd_q <= rd_next;
      s2_de <= s1_de;
      for (int k = 0; k < SYMS; k++)
        s2_idx[k] <= {s1_inv[k], s1_ent[k].qm};
    end
  end

  // stage 3: final code lookup and packing
  for (genvar k = 0; k < SYMS; k++) begin : g_s3
    tmds_code_lut u_clut (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (s2_de),
      .idx    (s2_idx[k]),
      .code_q (ser_word[k*SYM_W +: SYM_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_valid <= 1'b0;
    else        ser_valid <= s2_de;
  end

endmodule

// File: rtl/tmds_dual_enc_sva.sv
module tmds_dual_enc_sva
  import tmds_dual_pkg::*;
#(
  parameter int SYMS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vid_de,
  input logic                   ser_valid,
  input logic [SYM_W*SYMS-1:0]  ser_word,
  input logic                   rd_upd,
  input disp_t                  rd_q
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (ser_valid == $past(vid_de, 3)));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> (ser_word == '0));

  assert_disp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_upd |=> $stable(rd_q));

  assert_disp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q >= -6'sd8) && (rd_q <= 6'sd8) && !rd_q[0]);

endmodule

bind tmds_dual_enc tmds_dual_enc_sva #(.SYMS(SYMS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .vid_de    (vid_de),
  .ser_valid (ser_valid),
  .ser_word  (ser_word),
  .rd_upd    (rd_upd),
  .rd_q      (rd_q)
);

// File: tb/tmds_dual_enc_test.sv
`timescale 1ns/1ps
module tmds_dual_enc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vid_de = 1'b0;
  logic [15:0] vid_data = '0;
  logic [19:0] ser_word;
  logic        ser_valid;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  int out_disp = 0;
  bit done = 1'b0;
  logic [19:0] exp_q [$];
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #2 clk = ~clk;

  tmds_dual_enc #(.SYMS(2)) uut (
    .clk(clk), .rst_n(rst_n), .vid_de(vid_de),
    .vid_data(vid_data), .ser_word(ser_word), .ser_valid(ser_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // bit-serial reference written from the requirement text
  function automatic logic [9:0] ref_sym(input logic [7:0] d);
    logic [8:0] m;
    logic [9:0] o;
    int n1d, n1m;
    bit xn;
    n1d = 0;
    for (int i = 0; i < 8; i++) n1d += d[i];
    xn = (n1d > 4) || (n1d == 4 && d[0] == 1'b0);
    m[0] = d[0];
    for (int i = 1; i < 8; i++) m[i] = xn ? (m[i-1] ~^ d[i]) : (m[i-1] ^ d[i]);
    m[8] = !xn;
    n1m = 0;
    for (int i = 0; i < 8; i++) n1m += m[i];
    if (ref_cnt == 0 || n1m == 4) o[9] = ~m[8];
    else if ((ref_cnt > 0 && n1m > 4) || (ref_cnt < 0 && n1m < 4)) o[9] = 1'b1;
    else o[9] = 1'b0;
    o[8] = m[8];
    o[7:0] = o[9] ? ~m[7:0] : m[7:0];
    for (int i = 0; i < 10; i++) ref_cnt += o[i] ? 1 : -1;
    return o;
  endfunction

  task automatic beat(input bit de, input logic [7:0] b0, input logic [7:0] b1);
    logic [9:0] w0, w1;
    @(negedge clk);
    vid_de = de;
    vid_data = {b1, b0};
    if (de) begin
      w0 = ref_sym(b0);
      w1 = ref_sym(b1);
      exp_q.push_back({w1, w0});
    end
  endtask

  task automatic drain(input string req);
    beat(1'b0, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, 20'(exp_q.size()), 20'd0);
  endtask

  // monitor: every valid word against the reference, idle words zero
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected valid", ser_word, 20'd0);
        else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          chk(ser_word == e, "R1/R2/R3/R4 word", ser_word, e);
          out_disp += 2 * $countones(ser_word[9:0]) - 10;
          chk(out_disp >= -8 && out_disp <= 8, "R9 disparity bound", 20'(out_disp), 20'd8);
          out_disp += 2 * $countones(ser_word[19:10]) - 10;
          chk(out_disp >= -8 && out_disp <= 8, "R9 disparity bound", 20'(out_disp), 20'd8);
        end
      end else begin
        chk(ser_word == 20'd0, "R7 idle word", ser_word, 20'd0);
      end
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ser_valid == 1'b0, "R8 reset valid", 20'(ser_valid), 20'd0);
    chk(ser_word == 20'd0, "R8 reset word", ser_word, 20'd0);
    rst_n = 1'b1;
  endtask

  // first pair after reset: fixed expected word shows zero start and chaining
  task automatic t_first_pair();
    beat(1'b1, 8'h00, 8'h00);
    @(negedge clk); vid_de = 1'b0;
    chk(ser_valid == 1'b0, "R6 latency c1", 20'(ser_valid), 20'd0);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R6 latency c2", 20'(ser_valid), 20'd0);
    @(negedge clk);
    chk(ser_valid == 1'b1, "R6 latency c3", 20'(ser_valid), 20'd1);
    chk(ser_word == 20'hFFD00, "R8/R4 first pair", ser_word, 20'hFFD00);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R6 latency c4", 20'(ser_valid), 20'd0);
    drain("R6 first drain");
  endtask

  task automatic t_edge_bytes();
    beat(1'b1, 8'hFF, 8'h00);
    beat(1'b1, 8'h1E, 8'h0F);
    beat(1'b1, 8'h55, 8'hAA);
    beat(1'b1, 8'h10, 8'hF0);
    beat(1'b1, 8'h01, 8'h80);
    drain("R2 edge bytes");
  endtask

  task automatic t_runs();
    for (int i = 0; i < 40; i++) beat(1'b1, 8'hFF, 8'hFE);
    for (int i = 0; i < 40; i++) beat(1'b1, 8'h01, 8'h00);
    for (int i = 0; i < 40; i++) beat(1'b1, 8'h7F, 8'h08);
    drain("R3/R9 runs");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 60; i++) begin
      beat(1'b1, 8'(i * 37), 8'(i * 11 + 5));
      if (i % 3 == 0) beat(1'b0, 8'hFF, 8'hFF);
      if (i % 7 == 0) begin beat(1'b0, 8'h3C, 8'h00); beat(1'b0, 8'h00, 8'h81); end
    end
    drain("R5/R7 gaps");
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      beat(lfsr[31:29] != 3'd0, lfsr[7:0], lfsr[15:8]);
    end
    drain("R4/R5 random");
  endtask

  initial begin
    t_reset();
    t_first_pair();
    t_edge_bytes();
    t_runs();
    t_gaps();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule